// File: doc/BRIEF.md
# Boot and Wake Path Selector

This block is a short sequencer that runs once after every reset or wake-up. Three retention words sit outside the block: a mode word, a magic word and a branch-address word. The block reads them, together with a cold-boot flag and the code of the detected boot device, and chooses one start-up path. The four paths are serial download, full memory bring-up followed by the normal next stage, partial memory bring-up with a return to a saved address, and release of the secondary core to a saved address. The block also issues the write-backs that the retention words need on the way.

The memory controller and the cores are outside this block. A bring-up request is a level output that stays high until the matching done input is seen. Each path is reported as a one-cycle pulse on its own output. The jump-address output is valid while that pulse is high. A write-back changes the external word at the same clock edge on which the block issues it, so the new value is visible on the next cycle.

Top module: `boot_path_sel`

## Requirements
- R1: When `start` is accepted with `cold_boot` high, the cycle after acceptance writes zero to the magic word, and the path decision that follows uses the cleared value.
- R2: When bits 7:0 of the mode word equal 0xFF, the serial path (`path_serial`) is taken. Zero is written to the whole mode word in the cycle just before the pulse, and `jump_addr` reads zero during the pulse.
- R3: The serial check wins over the magic word. A mode byte of 0xFF selects serial whatever the magic value, and no memory bring-up is requested.
- R4: Any other value of mode bits 7:0 has no effect on which path is chosen. The magic word alone decides.
- R5: A magic word other than 0xCA7FACE0 and 0xCA7FACE1 raises `mem_full_req`. After `mem_done`, `path_normal` pulses and `jump_addr` equals the `NORMAL_ENTRY` parameter.
- R6: A magic word of 0xCA7FACE0 raises `mem_part_req`. After `mem_done`, `path_resume` pulses and `jump_addr` equals the branch word.
- R7: A magic word of 0xCA7FACE1 pulses `path_secondary` one cycle after the decision, with `jump_addr` equal to the branch word and no memory request.
- R8: On every non-serial path the decision cycle writes the mode word with the boot-device code in bits 15:8. All other bits keep their values.
- R9: The four path outputs are one-hot or all zero, and each pulse lasts exactly one cycle. A bring-up request stays high until `mem_done` is seen, and the path pulses on the cycle after that.
- R10: A warm start (`cold_boot` low) never writes the magic word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a selection run; accepted while idle |
| cold_boot | input | 1 | Run follows a cold power-up |
| boot_dev | input | 8 | Detected boot-device code |
| mode_word | input | 32 | Current mode retention word |
| magic_word | input | 32 | Current magic retention word |
| branch_word | input | 32 | Current branch-address retention word |
| mem_done | input | 1 | Memory bring-up finished |
| mode_we | output | 1 | Write strobe for the mode word |
| mode_wdata | output | 32 | New mode word value |
| magic_we | output | 1 | Write strobe for the magic word |
| magic_wdata | output | 32 | New magic word value |
| mem_full_req | output | 1 | Request full memory bring-up |
| mem_part_req | output | 1 | Request self-refresh exit only |
| path_serial | output | 1 | Serial download path pulse |
| path_normal | output | 1 | Normal next-stage path pulse |
| path_resume | output | 1 | Resume-from-standby path pulse |
| path_secondary | output | 1 | Secondary-core release pulse |
| jump_addr | output | 32 | Target address, valid with a path pulse |
| busy | output | 1 | A selection run is in progress |

## Verification
The bench sweeps the mode low byte over 0xFF, 0xFE, 0x00 and 0x7F. It crosses these with five magic values: both signatures, zero, a value one above the secondary signature, and an unrelated value. Each combination runs both cold and warm, with the done delay and device code varied. The 0xFF cases with each signature show that the serial check has priority. The near-miss bytes show that they are ignored. Cold runs that hold a signature show that the clear happens before the decision: they must fall through to full bring-up. The off-by-one magic value separates an exact compare from a partial one.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR_MAGIC,
        ST_EVAL,
        ST_WAIT_FULL,
        ST_WAIT_PART
    } bps_state_e;

    typedef enum logic [1:0] {
        PK_SERIAL,
        PK_FULL,
        PK_RESUME,
        PK_SECOND
    } bps_pick_e;

    localparam int N_PATH = 4;
    localparam int P_SERIAL = 0;
    localparam int P_NORMAL = 1;
    localparam int P_RESUME = 2;
    localparam int P_SECOND = 3;
endpackage

// File: rtl/bps_classify.sv
module bps_classify
    import bps_pkg::*;
#(
    parameter int          W            = 32,
    parameter int          SEL_W        = 8,
    parameter logic [7:0]  SERIAL_CODE  = 8'hFF,
    parameter logic [31:0] MAGIC_RESUME = 32'hCA7F_ACE0,
    parameter logic [31:0] MAGIC_SECOND = 32'hCA7F_ACE1
) (
    input  logic [W-1:0] mode_word,
    input  logic [W-1:0] magic_word,
    output bps_pick_e    pick
);
    localparam logic [SEL_W-1:0] SER_V = SEL_W'(SERIAL_CODE);
    localparam logic [W-1:0]     RES_V = W'(MAGIC_RESUME);
    localparam logic [W-1:0]     SEC_V = W'(MAGIC_SECOND);

    always_comb begin
        if (mode_word[SEL_W-1:0] == SER_V) begin
            pick = PK_SERIAL;
        end else if (magic_word == RES_V) begin
            pick = PK_RESUME;
        end else if (magic_word == SEC_V) begin
            pick = PK_SECOND;
        end else begin
            pick = PK_FULL;
        end
    end
endmodule

// File: rtl/bps_seq.sv
module bps_seq
    import bps_pkg::*;
#(
    parameter int          W            = 32,
    parameter int          DEV_W        = 8,
    parameter int          DEV_LSB      = 8,
    parameter logic [31:0] NORMAL_ENTRY = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cold_boot,
    input  bps_pick_e         pick,
    input  logic [DEV_W-1:0]  boot_dev,
    input  logic [W-1:0]      mode_word,
    input  logic [W-1:0]      branch_word,
    input  logic              mem_done,
    output logic              busy,
    output logic              mode_we,
    output logic [W-1:0]      mode_wdata,
    output logic              magic_we,
    output logic [W-1:0]      magic_wdata,
    output logic              mem_full_req,
    output logic              mem_part_req,
    output logic [N_PATH-1:0] path,
    output logic [W-1:0]      jump_addr
);
    typedef struct packed {
        bps_state_e        st;
        logic [N_PATH-1:0] path;
        logic [W-1:0]      jump;
    } seq_t;

    seq_t reg_d, reg_q;

    always_comb begin
        reg_d       = reg_q;
        reg_d.path  = '0;
        mode_we     = 1'b0;
        mode_wdata  = mode_word;
        magic_we    = 1'b0;
        magic_wdata = '0;
        unique case (reg_q.st)
            ST_IDLE: begin
                if (start) reg_d.st = cold_boot ? ST_CLR_MAGIC : ST_EVAL;
            end
            ST_CLR_MAGIC: begin
                magic_we = 1'b1;
                reg_d.st = ST_EVAL;
            end
            ST_EVAL: begin
                mode_we = 1'b1;
                if (pick == PK_SERIAL) begin
                    mode_wdata           = '0;
                    reg_d.path[P_SERIAL] = 1'b1;
                    reg_d.jump           = '0;
                    reg_d.st             = ST_IDLE;
                end else begin
                    mode_wdata[DEV_LSB +: DEV_W] = boot_dev;
                    unique case (pick)
                        PK_SECOND: begin
                            reg_d.path[P_SECOND] = 1'b1;
                            reg_d.jump           = branch_word;
                            reg_d.st             = ST_IDLE;
                        end
                        PK_RESUME: begin
                            reg_d.jump = branch_word;
                            reg_d.st   = ST_WAIT_PART;
                        end
                        default: begin
                            reg_d.jump = W'(NORMAL_ENTRY);
                            reg_d.st   = ST_WAIT_FULL;
                        end
                    endcase
                end
            end
            ST_WAIT_FULL: begin
                if (mem_done) begin
                    reg_d.path[P_NORMAL] = 1'b1;
                    reg_d.st             = ST_IDLE;
                end
            end
            ST_WAIT_PART: begin
                if (mem_done) begin
                    reg_d.path[P_RESUME] = 1'b1;
                    reg_d.st             = ST_IDLE;
                end
            end
            default: reg_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '{st: ST_IDLE, path: '0, jump: '0};
        end else begin
            reg_q <= reg_d;
        end
    end

    assign busy         = (reg_q.st != ST_IDLE);
    assign mem_full_req = (reg_q.st == ST_WAIT_FULL);
    assign mem_part_req = (reg_q.st == ST_WAIT_PART);
    assign path         = reg_q.path;
    assign jump_addr    = reg_q.jump;

    // R1: a cold start clears the magic word on the next cycle
    a_r1_cold_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cold_boot) |=> (magic_we && magic_wdata == '0));
    // R10: a warm start leaves the magic word alone
    a_r10_warm_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !cold_boot) |=> !magic_we);
    // R2: the serial pulse follows a full clear of the mode word
    a_r2_serial_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        path[P_SERIAL] |-> $past(mode_we && mode_wdata == '0));
    // R5: the normal path pulses only after full bring-up completes
    a_r5_normal_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        path[P_NORMAL] |-> $past(mem_full_req && mem_done));
    // R6: the resume path pulses only after partial bring-up completes
    a_r6_resume_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        path[P_RESUME] |-> $past(mem_part_req && mem_done));
    // R7: secondary release carries the branch word and needs no bring-up
    a_r7_second_target: assert property (@(posedge clk) disable iff (!rst_n)
        path[P_SECOND] |-> (jump_addr == $past(branch_word)
                            && !$past(mem_full_req) && !$past(mem_part_req)));
    // R9: path outputs are one-hot and last a single cycle
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(path));
    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        (path != '0) |=> (path == '0));
    // R9: a bring-up request holds until done is seen
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_full_req && !mem_done) |=> mem_full_req);
endmodule

// File: rtl/boot_path_sel.sv
module boot_path_sel
    import bps_pkg::*;
#(
    parameter int          W            = 32,
    parameter int          SEL_W        = 8,
    parameter int          DEV_W        = 8,
    parameter int          DEV_LSB      = 8,
    parameter logic [7:0]  SERIAL_CODE  = 8'hFF,
    parameter logic [31:0] MAGIC_RESUME = 32'hCA7F_ACE0,
    parameter logic [31:0] MAGIC_SECOND = 32'hCA7F_ACE1,
    parameter logic [31:0] NORMAL_ENTRY = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cold_boot,
    input  logic [DEV_W-1:0] boot_dev,
    input  logic [W-1:0]     mode_word,
    input  logic [W-1:0]     magic_word,
    input  logic [W-1:0]     branch_word,
    input  logic             mem_done,
    output logic             mode_we,
    output logic [W-1:0]     mode_wdata,
    output logic             magic_we,
    output logic [W-1:0]     magic_wdata,
    output logic             mem_full_req,
    output logic             mem_part_req,
    output logic             path_serial,
    output logic             path_normal,
    output logic             path_resume,
    output logic             path_secondary,
    output logic [W-1:0]     jump_addr,
    output logic             busy
);
    bps_pick_e         pick;
    logic [N_PATH-1:0] path_vec;

    bps_classify #(
        .W(W), .SEL_W(SEL_W), .SERIAL_CODE(SERIAL_CODE),
        .MAGIC_RESUME(MAGIC_RESUME), .MAGIC_SECOND(MAGIC_SECOND)
    ) u_classify (
        .mode_word (mode_word),
        .magic_word(magic_word),
        .pick      (pick)
    );

    bps_seq #(
        .W(W), .DEV_W(DEV_W), .DEV_LSB(DEV_LSB), .NORMAL_ENTRY(NORMAL_ENTRY)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cold_boot   (cold_boot),
        .pick        (pick),
        .boot_dev    (boot_dev),
        .mode_word   (mode_word),
        .branch_word (branch_word),
        .mem_done    (mem_done),
        .busy        (busy),
        .mode_we     (mode_we),
        .mode_wdata  (mode_wdata),
        .magic_we    (magic_we),
        .magic_wdata (magic_wdata),
        .mem_full_req(mem_full_req),
        .mem_part_req(mem_part_req),
        .path        (path_vec),
        .jump_addr   (jump_addr)
    );

    assign path_serial    = path_vec[P_SERIAL];
    assign path_normal    = path_vec[P_NORMAL];
    assign path_resume    = path_vec[P_RESUME];
    assign path_secondary = path_vec[P_SECOND];
endmodule

// File: tb/sim_boot_path_sel.sv
`timescale 1ns/1ps
module sim_boot_path_sel;
    localparam logic [31:0] ENTRY = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cold_boot = 1'b0;
    logic [7:0]  boot_dev = '0;
    logic [31:0] mode_r = '0, magic_r = '0, branch_r = '0;
    logic        mem_done = 1'b0;
    logic        mode_we, magic_we, mem_full_req, mem_part_req;
    logic [31:0] mode_wdata, magic_wdata, jump_addr;
    logic        path_serial, path_normal, path_resume, path_secondary, busy;

    int n_chk = 0, n_bad = 0, cyc = 0, done_dly = 1, req_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    boot_path_sel #(.NORMAL_ENTRY(ENTRY)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cold_boot(cold_boot),
        .boot_dev(boot_dev), .mode_word(mode_r), .magic_word(magic_r),
        .branch_word(branch_r), .mem_done(mem_done),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .magic_we(magic_we),
        .magic_wdata(magic_wdata), .mem_full_req(mem_full_req),
        .mem_part_req(mem_part_req), .path_serial(path_serial),
        .path_normal(path_normal), .path_resume(path_resume),
        .path_secondary(path_secondary), .jump_addr(jump_addr), .busy(busy)
    );

    // retention word model
    always @(posedge clk) begin
        if (mode_we)  mode_r  <= mode_wdata;
        if (magic_we) magic_r <= magic_wdata;
    end

    // memory bring-up responder
    always @(negedge clk) begin
        if (mem_full_req || mem_part_req) begin
            req_cnt  = req_cnt + 1;
            mem_done = (req_cnt == done_dly);
        end else begin
            req_cnt  = 0;
            mem_done = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    task automatic run_case(input logic [31:0] mode_in, input logic [31:0] magic_in,
                            input logic [31:0] br, input bit cold,
                            input logic [7:0] dev, input int dly);
        logic [31:0] eff_magic, exp_mode, exp_jump;
        logic [3:0]  exp_path, got_path;
        int exp_at, pulse_at, pulses, full_seen, part_seen, magic_wr;
        bit serial;
        @(negedge clk);
        mode_r = mode_in; magic_r = magic_in; branch_r = br;
        cold_boot = cold; boot_dev = dev; done_dly = dly;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        eff_magic = cold ? 32'h0 : magic_in;
        serial = (mode_in[7:0] == 8'hFF);
        if (serial)                         exp_path = 4'b0001;
        else if (eff_magic == 32'hCA7FACE0) exp_path = 4'b0100;
        else if (eff_magic == 32'hCA7FACE1) exp_path = 4'b1000;
        else                                exp_path = 4'b0010;
        exp_mode = serial ? 32'h0 : {mode_in[31:16], dev, mode_in[7:0]};
        exp_jump = exp_path[0] ? 32'h0 : (exp_path[1] ? ENTRY : br);
        exp_at   = (cold ? 3 : 2) + ((exp_path[1] || exp_path[2]) ? dly : 0);
        pulse_at = 0; pulses = 0; full_seen = 0; part_seen = 0; magic_wr = 0;
        got_path = '0;
        for (int s = 1; s <= 20; s++) begin
            if (magic_we) magic_wr++;
            if (mem_full_req) full_seen++;
            if (mem_part_req) part_seen++;
            if (path_serial | path_normal | path_resume | path_secondary) begin
                pulses += $countones({path_secondary, path_resume, path_normal, path_serial});
                if (pulse_at == 0) begin
                    pulse_at = s;
                    got_path = {path_secondary, path_resume, path_normal, path_serial};
                    check("R5/R6/R7 jump", jump_addr, exp_jump);
                end
            end
            @(negedge clk);
        end
        // R3 R4: path chosen by serial byte first, then magic alone
        check("R3/R4 path", {28'h0, got_path}, {28'h0, exp_path});
        // R9: exactly one single-cycle pulse at the expected cycle
        check("R9 pulse count", pulses, 1);
        check("R9 pulse cycle", pulse_at, exp_at);
        // R2 R8: mode word after the run
        check("R2/R8 mode", mode_r, exp_mode);
        // R1 R10: magic word cleared only on cold start
        check("R1/R10 magic", magic_r, eff_magic);
        check("R1/R10 magic writes", magic_wr, cold ? 1 : 0);
        // R5 R6 R7 R3: request cycles equal the done delay on the right line
        check("R5 full req cycles", full_seen, exp_path[1] ? dly : 0);
        check("R6 part req cycles", part_seen, exp_path[2] ? dly : 0);
        check("R9 idle after", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        logic [7:0]  lows [4];
        logic [31:0] magics [5];
        lows[0] = 8'hFF; lows[1] = 8'hFE; lows[2] = 8'h00; lows[3] = 8'h7F;
        magics[0] = 32'hCA7FACE0; magics[1] = 32'hCA7FACE1; magics[2] = 32'h0;
        magics[3] = 32'hCA7FACE2; magics[4] = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        // reset state
        check("R9 reset paths", {28'h0, path_secondary, path_resume, path_normal, path_serial}, 32'h0);
        check("R9 reset busy", {31'h0, busy}, 32'h0);
        check("R5 reset req", {30'h0, mem_full_req, mem_part_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int li = 0; li < 4; li++) begin
            for (int mi = 0; mi < 5; mi++) begin
                for (int c = 0; c < 2; c++) begin
                    run_case({8'hA5, 8'h3C, 8'h99, lows[li]}, magics[mi],
                             32'h8000_0000 + 32'(li * 64 + mi * 8 + c * 4),
                             c[0], 8'(8'h11 * (mi + 1) + li), 1 + ((li + mi + c) % 3));
                end
            end
        end
        finish_run();
    end
endmodule